// File: doc/BRIEF.md
# Reloading Cycle Timer with Interrupt Gating

A free-running down-counter steps once per clock. When the counter is at zero, the next clock loads it with a programmable reload value instead of letting it wrap. A reload value R therefore gives a zero event every R+1 cycles. Every zero event sets a sticky pending flag. That flag stays set until an explicit clear strobe removes it, even while the interrupt is masked.

The interrupt request line is a registered copy of the pending flag. It is gated by three controls: an enable bit stored next to the reload value, a global disable-all input, and a multi-bit timer-disable field in which any set bit masks the request. The ordinary external-interrupt disable input is brought into the block on purpose and has no influence on the timer request.

Software reaches the counter and the reload register through a small write/read port. Reads are registered and return data one cycle after the address is presented.

Top module: `cycle_timer_irq`

## Requirements
- R1: On reset the counter, the reload value, the interrupt enable, the pending flag, the request line and the read data are all zero.
- R2: When it is not written and not zero, the counter decreases by exactly one per clock. Address 0 reads the counter in bits [23:0], and the read data shows the value held one cycle before.
- R3: On the clock after the counter is at zero, the counter takes the reload value and does not wrap to all ones. With reload value R, zero events repeat every R+1 cycles.
- R4: Each clock edge that sees the counter at zero sets the pending flag, whatever the enable and disable controls are.
- R5: The pending flag is cleared only by the clear strobe. When a clear and a zero event meet on the same edge, the flag stays set.
- R6: The request line is set on the edge after the pending flag is set, if at that edge the enable bit is 1, the disable-all input is 0 and every bit of the timer-disable field is 0. Otherwise the request line is 0.
- R7: The external-interrupt disable input has no effect on the request line or on the pending flag.
- R8: A write to address 0 loads the counter with write data bits [23:0]. This write overrides both the decrement and the reload on the same edge.
- R9: With a reload value of zero, the counter sits at zero and the pending flag is set again on every cycle, so a clear strobe cannot drop it.
- R10: Address 1 holds the reload value in bits [23:0] and the interrupt enable in bit 24, for both write and read. Addresses 2 and 3 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 25 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 25 | Registered read data, one cycle latency |
| cfg_disable_all | input | 1 | Global disable-all control; masks the request |
| tmr_dis_field | input | 2 | Timer-disable field; any set bit masks the request |
| ext_int_disable | input | 1 | External-interrupt disable; ignored by the timer |
| pend_clr | input | 1 | Clear strobe for the pending flag |
| irq_pending | output | 1 | Sticky pending flag |
| irq_req | output | 1 | Registered timer interrupt request |

## Verification
Assertions check these rules on every cycle: the one-step decrement, the reload taken at zero, the priority of a counter write, the sticky flag and the priority of a zero event over a clear, the masking of the request, and the register map side effects. Only the bench's scenarios can show the end-to-end timing. It sweeps start counts and reload values with the enable on and off and measures the cycle distance to each zero event. It also checks that the request follows a pending flag one cycle later. Finally, it steps through every combination of disable-all, timer-disable field and external disable, and checks that the external disable leaves the request unchanged.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd1;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int REG_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic [CNT_W-1:0]  cnt,
  output logic              cnt_ld,
  output logic [CNT_W-1:0]  cnt_ld_val,
  output logic [CNT_W-1:0]  reload_val,
  output logic              irq_en
);
  localparam int EN_BIT = CNT_W;

  logic reload_wr;

  assign cnt_ld     = wr_en && (wr_addr == ADDR_COUNT);
  assign reload_wr  = wr_en && (wr_addr == ADDR_RELOAD);
  assign cnt_ld_val = wr_data[CNT_W-1:0];

  // Reload value and interrupt enable share one register word
  always_ff @(posedge clk) begin
    if (rst) begin
      reload_val <= '0;
      irq_en     <= 1'b0;
    end else if (reload_wr) begin
      reload_val <= wr_data[CNT_W-1:0];
      irq_en     <= wr_data[EN_BIT];
    end
  end

  // Registered read mux
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        ADDR_COUNT:  rd_data <= {1'b0, cnt};
        ADDR_RELOAD: rd_data <= {irq_en, reload_val};
        default:     rd_data <= '0;
      endcase
    end
  end

  p_reload_wr_r10: assert property (@(posedge clk) disable iff (rst)
    reload_wr |=> (reload_val == $past(wr_data[CNT_W-1:0])) && (irq_en == $past(wr_data[EN_BIT])));

  p_unmapped_rd_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_addr != ADDR_COUNT && rd_addr != ADDR_RELOAD) |=> (rd_data == '0));

  p_reload_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !reload_wr |=> $stable(reload_val) && $stable(irq_en));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign zero = (cnt == '0);

  // Software load first, then reload at zero, then decrement
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (zero) cnt <= reload_val;
    else           cnt <= cnt - ONE;
  end

  p_dec_r2: assert property (@(posedge clk) disable iff (rst)
    (!ld && cnt != '0) |=> (cnt == $past(cnt) - ONE));

  p_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (!ld && cnt == '0) |=> (cnt == $past(reload_val)));

  p_wr_prio_r8: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/tmr_irq_gate.sv
module tmr_irq_gate #(
  parameter int TD_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            zero,
  input  logic            clr,
  input  logic            irq_en,
  input  logic            dis_all,
  input  logic [TD_W-1:0] td,
  input  logic            ext_dis,
  output logic            pend,
  output logic            req
);
  logic pass;

  // The external-interrupt disable is deliberately left out of this gate
  assign pass = irq_en && !dis_all && (td == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      req  <= 1'b0;
    end else begin
      if (zero)     pend <= 1'b1;
      else if (clr) pend <= 1'b0;
      req <= pend && pass;
    end
  end

  p_zero_sets_r4: assert property (@(posedge clk) disable iff (rst)
    zero |=> pend);

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> pend);

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (clr && !zero) |=> !pend);

  p_masked_r6: assert property (@(posedge clk) disable iff (rst)
    (!irq_en || dis_all || (td != '0) || !pend) |=> !req);

  p_ext_dis_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (ext_dis && pend && irq_en && !dis_all && (td == '0)) |=> req);
endmodule

// File: rtl/cycle_timer_irq.sv
module cycle_timer_irq
  import tmr_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int TD_W  = 2,
  parameter int REG_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              cfg_disable_all,
  input  logic [TD_W-1:0]   tmr_dis_field,
  input  logic              ext_int_disable,
  input  logic              pend_clr,
  output logic              irq_pending,
  output logic              irq_req
);
  logic [CNT_W-1:0] cnt;
  logic             cnt_ld;
  logic [CNT_W-1:0] cnt_ld_val;
  logic [CNT_W-1:0] reload_val;
  logic             irq_en;
  logic             zero;

  tmr_regs #(.CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .cnt        (cnt),
    .cnt_ld     (cnt_ld),
    .cnt_ld_val (cnt_ld_val),
    .reload_val (reload_val),
    .irq_en     (irq_en)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .ld         (cnt_ld),
    .ld_val     (cnt_ld_val),
    .reload_val (reload_val),
    .cnt        (cnt),
    .zero       (zero)
  );

  tmr_irq_gate #(.TD_W(TD_W)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .zero    (zero),
    .clr     (pend_clr),
    .irq_en  (irq_en),
    .dis_all (cfg_disable_all),
    .td      (tmr_dis_field),
    .ext_dis (ext_int_disable),
    .pend    (irq_pending),
    .req     (irq_req)
  );
endmodule

// File: tb/tb_cycle_timer_irq.sv
`timescale 1ns/1ps
module tb_cycle_timer_irq;
  localparam int CNT_W = 24;
  localparam int REG_W = CNT_W + 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [REG_W-1:0] wr_data = '0;
  logic [1:0]       rd_addr = '0;
  logic [REG_W-1:0] rd_data;
  logic             cfg_disable_all = 1'b0;
  logic [1:0]       tmr_dis_field = '0;
  logic             ext_int_disable = 1'b0;
  logic             pend_clr = 1'b0;
  logic             irq_pending;
  logic             irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cycle_timer_irq dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cfg_disable_all(cfg_disable_all),
    .tmr_dis_field(tmr_dis_field), .ext_int_disable(ext_int_disable),
    .pend_clr(pend_clr), .irq_pending(irq_pending), .irq_req(irq_req)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [REG_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) step();
    // R1: reset state
    chk(irq_pending == 1'b0, "R1", irq_pending, 0);
    chk(irq_req == 1'b0, "R1", irq_req, 0);
    chk(rd_data == '0, "R1", rd_data, 0);
    rst = 1'b0;
    rd_addr = 2'd1;
    step();
    chk(rd_data == '0, "R1", rd_data, 0);
    chk(irq_pending == 1'b1, "R4", irq_pending, 1); // counter at zero after reset
    step();
    chk(irq_req == 1'b0, "R6", irq_req, 0);         // enable still clear
    rd_addr = 2'd0;

    // Sweep start count, reload value and enable
    for (int en = 0; en < 2; en++) begin
      for (int n = 1; n <= 5; n++) begin
        for (int r = 0; r <= 3; r++) begin
          wr(2'd1, {en[0], 24'(r)});
          wr(2'd0, {1'b0, 24'(n)});
          pend_clr = 1'b1;
          step();
          pend_clr = 1'b0;
          chk(irq_pending == 1'b0, "R5", irq_pending, 0);
          for (int k = 1; k <= n; k++) begin
            step();
            chk(rd_data == REG_W'(n - k), "R2", rd_data, n - k);
            chk(irq_pending == (k == n), "R3", irq_pending, (k == n));
          end
          pend_clr = 1'b1;
          step();
          chk(irq_req == en[0], "R6", irq_req, en);
          chk(rd_data == REG_W'(r), "R3", rd_data, r);
          chk(irq_pending == (r == 0), "R5", irq_pending, (r == 0));
          if (r == 0) begin
            for (int k = 0; k < 3; k++) begin
              step();
              chk(irq_pending == 1'b1, "R9", irq_pending, 1);
            end
            pend_clr = 1'b0;
          end else begin
            pend_clr = 1'b0;
            for (int k = 1; k <= r; k++) begin
              step();
              chk(irq_pending == (k == r), "R3", irq_pending, (k == r));
            end
          end
        end
      end
    end

    // Gating sweep with pending held by reload zero
    wr(2'd1, {1'b1, 24'd0});
    repeat (8) step();
    for (int d = 0; d < 2; d++) begin
      for (int t = 0; t < 4; t++) begin
        for (int x = 0; x < 2; x++) begin
          cfg_disable_all = d[0];
          tmr_dis_field   = t[1:0];
          ext_int_disable = x[0];
          step();
          chk(irq_pending == 1'b1, "R4", irq_pending, 1);
          chk(irq_req == (d == 0 && t == 0), "R6", irq_req, (d == 0 && t == 0));
          if (d == 0 && t == 0)
            chk(irq_req == 1'b1, "R7", irq_req, 1);
        end
      end
    end
    cfg_disable_all = 1'b0;
    tmr_dis_field = '0;
    wr(2'd1, {1'b0, 24'd0});
    for (int x = 0; x < 2; x++) begin
      ext_int_disable = x[0];
      step();
      chk(irq_req == 1'b0, "R7", irq_req, 0);
    end
    ext_int_disable = 1'b0;

    // R8: write wins over reload while counter sits at zero
    rd_addr = 2'd0;
    wr(2'd0, {1'b0, 24'd9});
    step();
    chk(rd_data == 25'd9, "R8", rd_data, 9);
    step();
    chk(rd_data == 25'd8, "R8", rd_data, 8);

    // R10: register map
    wr(2'd1, {1'b1, 24'h00ABCD});
    rd_addr = 2'd1;
    step();
    chk(rd_data == 25'h100ABCD, "R10", rd_data, 25'h100ABCD);
    wr(2'd2, 25'h1FFFFFF);
    wr(2'd3, 25'h1FFFFFF);
    step();
    chk(rd_data == 25'h100ABCD, "R10", rd_data, 25'h100ABCD);
    rd_addr = 2'd2;
    step();
    chk(rd_data == '0, "R10", rd_data, 0);
    rd_addr = 2'd3;
    step();
    chk(rd_data == '0, "R10", rd_data, 0);
    rd_addr = 2'd0;
    step();
    chk(rd_data < 25'h00ABCE, "R10", rd_data, 25'h00ABCD);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule